// File: doc/BRIEF.md
# Peripheral Clock Enable Bank with Set/Clear Registers

This block holds one clock-enable flop per peripheral and gives software three ways to reach them through a single-cycle register bus. A write to a set register turns on every peripheral whose bit is 1. A write to a clear register turns off every peripheral whose bit is 1. A status register reads back the live enable state. Zero bits in a set or clear write leave their peripherals unchanged, so independent drivers can gate their own clocks without a read-modify-write.

The peripheral space is split into banks of `DATA_W` bits. Each bank has its own set, clear and status word, and peripheral n sits at bit n mod `DATA_W` of bank n / `DATA_W`. The lowest `ALWAYS_ON` peripherals are never gated. Their enables stay at 1 through reset and through every write, and their status bits always read 1. The `clk_en` outputs are meant to drive clock-gating cells elsewhere in the chip.

Top module: `pcg_bank`

## Requirements
- R1: A write with `wr_en` high to function code 0 (`addr[1:0]`=0, set) of bank `addr[2]` sets `clk_en[32*addr[2]+k]` for every k where `wr_data[k]`=1. Peripherals whose bit is 0 keep their state.
- R2: A write with `wr_en` high to function code 1 (`addr[1:0]`=1, clear) clears `clk_en[32*addr[2]+k]` for every k where `wr_data[k]`=1. Peripherals whose bit is 0 keep their state.
- R3: A read with `rd_en` high to function code 2 (`addr[1:0]`=2, status) loads `rd_data` with the enable state of bank `addr[2]` as it stood at that edge. `rd_data` is valid from the next cycle and holds its value while `rd_en` is low.
- R4: Peripherals 0 and 1 are always enabled. Their `clk_en` bits are 1 at all times, set and clear writes do not affect them, and their status bits read 1.
- R5: Bank 1 (`addr[2]`=1) covers peripherals 32 to 63, with bit k controlling peripheral 32+k. Writes to one bank never alter the other bank.
- R6: While `rst_n` is low, every enable except peripherals 0 and 1 is 0 and `rd_data` is 0.
- R7: Enables are registered. A write changes `clk_en` in the cycle after the one in which `wr_en` is sampled high. `clk_en` does not change in any cycle without a write.
- R8: Writes to function codes 2 (status) and 3 (reserved) have no effect on `clk_en`. A read of function codes 0, 1 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and enable clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Word address: bits [1:0] select the function, bit 2 selects the bank |
| wr_data | input | 32 | Write data, one bit per peripheral of the bank |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 32 | Registered read data |
| clk_en | output | 64 | Per-peripheral clock enable |

## Verification
The hardest case to reach is the always-on guarantee under pressure. A clear of the low bank must be seen not to disturb peripherals 0 and 1 while it does clear all of their neighbours. A mismatch would only show up if a clear with those bits set arrived when the other bits were in a known state. Directed all-ones set and clear writes to both banks create that situation. A fixed-seed random mix of writes and reads over every function code then keeps probing it, with each result compared against a bench model of the enable vector. Timing is checked by sampling `clk_en` both before and after the strobed edge.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;

  // Function selected by the two low address bits.
  typedef enum logic [1:0] {
    FN_SET  = 2'd0,
    FN_CLR  = 2'd1,
    FN_STAT = 2'd2,
    FN_RSVD = 2'd3
  } fn_e;

  function automatic fn_e fn_of(input logic [1:0] low_addr);
    return fn_e'(low_addr);
  endfunction

  // Next state of one enable flop; clear dominates set, pinned cells stay on.
  function automatic logic next_enable(input logic cur, input logic set_b,
                                       input logic clr_b, input logic pinned);
    logic nxt;
    if (clr_b)      nxt = 1'b0;
    else if (set_b) nxt = 1'b1;
    else            nxt = cur;
    return pinned | nxt;
  endfunction

endpackage

// File: rtl/pcg_decode.sv
`timescale 1ns/1ps
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  wr_en,
  output logic [NUM_PERIPH-1:0] set_vec,
  output logic [NUM_PERIPH-1:0] clr_vec
);
  localparam int NUM_BANKS = NUM_PERIPH / DATA_W;
  localparam int BANK_W    = ADDR_W - 2;

  fn_e              fn;
  logic [BANK_W-1:0] bank;

  assign fn   = fn_of(addr[1:0]);
  assign bank = addr[ADDR_W-1:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (bank == BANK_W'(b));
    assign set_vec[b*DATA_W +: DATA_W] = (hit && fn == FN_SET) ? wr_data : '0;
    assign clr_vec[b*DATA_W +: DATA_W] = (hit && fn == FN_CLR) ? wr_data : '0;
  end

endmodule

// File: rtl/pcg_cell.sv
`timescale 1ns/1ps
module pcg_cell
  import pcg_pkg::*;
#(
  parameter bit PINNED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= PINNED;
    else        en_q <= next_enable(en_q, set_i, clr_i, PINNED);
  end

  assign en_o = en_q;

endmodule

// File: rtl/pcg_readback.sv
`timescale 1ns/1ps
module pcg_readback
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd_en,
  input  logic [NUM_PERIPH-1:0] en_vec,
  output logic [DATA_W-1:0]     rd_data
);
  localparam int NUM_BANKS = NUM_PERIPH / DATA_W;
  localparam int BANK_W    = ADDR_W - 2;

  logic [DATA_W-1:0] words [NUM_BANKS];
  logic [BANK_W-1:0] bank;
  logic              bank_ok;
  logic [DATA_W-1:0] rd_next;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_word
    assign words[b] = en_vec[b*DATA_W +: DATA_W];
  end

  assign bank    = addr[ADDR_W-1:2];
  assign bank_ok = (int'(bank) < NUM_BANKS);

  always_comb begin
    rd_next = '0;
    if (fn_of(addr[1:0]) == FN_STAT && bank_ok) rd_next = words[bank];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/pcg_bank.sv
`timescale 1ns/1ps
module pcg_bank #(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ALWAYS_ON  = 2,
  parameter int ADDR_W     = 2 + ((NUM_PERIPH / DATA_W > 1) ?
                                  $clog2(NUM_PERIPH / DATA_W) : 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_PERIPH-1:0] clk_en
);
  // Per-peripheral set and clear pulses, brought out for the checker.
  logic [NUM_PERIPH-1:0] set_vec;
  logic [NUM_PERIPH-1:0] clr_vec;

  pcg_decode #(
    .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_cell
    pcg_cell #(.PINNED(i < ALWAYS_ON)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_vec[i]), .clr_i(clr_vec[i]),
      .en_o(clk_en[i])
    );
  end

  pcg_readback #(
    .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_readback (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .en_vec(clk_en), .rd_data(rd_data)
  );

endmodule

// File: rtl/pcg_bank_chk.sv
`timescale 1ns/1ps
module pcg_bank_chk #(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 32,
  parameter int ALWAYS_ON  = 2,
  parameter int ADDR_W     = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [DATA_W-1:0]     rd_data,
  input logic [NUM_PERIPH-1:0] clk_en,
  input logic [NUM_PERIPH-1:0] set_vec,
  input logic [NUM_PERIPH-1:0] clr_vec
);
  function automatic logic [NUM_PERIPH-1:0] pin_mask();
    logic [NUM_PERIPH-1:0] m = '0;
    for (int i = 0; i < NUM_PERIPH; i++) m[i] = (i < ALWAYS_ON);
    return m;
  endfunction

  localparam logic [NUM_PERIPH-1:0] PIN = pin_mask();

  // R1
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((clk_en & $past(set_vec)) == $past(set_vec)));

  // R2
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((clk_en & $past(clr_vec) & ~PIN) == '0));

  // R4
  pinned_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en & PIN) == PIN));

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(clk_en));

  // R8
  inert_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1]) |=> $stable(clk_en));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind pcg_bank pcg_bank_chk #(
  .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W),
  .ALWAYS_ON(ALWAYS_ON), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .clk_en(clk_en), .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/sim_pcg_bank.sv
`timescale 1ns/1ps
module sim_pcg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [63:0] clk_en;

  int vectors = 0;
  int fails   = 0;
  logic [63:0] model;

  always #2.5 clk = ~clk;

  pcg_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .clk_en(clk_en)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench restatement of the register semantics.
  function automatic logic [63:0] apply(input logic [63:0] m,
                                        input logic [2:0] a,
                                        input logic [31:0] d);
    logic [63:0] wide = a[2] ? {d, 32'h0} : {32'h0, d};
    logic [63:0] r = m;
    case (a[1:0])
      2'd0: r = m | wide;
      2'd1: r = m & ~wide;
      default: r = m;
    endcase
    return r | 64'h3;
  endfunction

  function automatic logic [31:0] expect_rd(input logic [63:0] m,
                                            input logic [2:0] a);
    if (a[1:0] != 2'd2) return 32'h0;
    return a[2] ? m[63:32] : m[31:0];
  endfunction

  task automatic do_write(input logic [2:0] a, input logic [31:0] d,
                          input string req);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    #1 check({req, " pre-edge"}, clk_en, model);
    @(negedge clk);
    wr_en = 1'b0;
    model = apply(model, a, d);
    check(req, clk_en, model);
  endtask

  task automatic do_read(input logic [2:0] a, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, {32'h0, rd_data}, {32'h0, expect_rd(model, a)});
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    model = 64'h3;
    seed_dummy = $urandom(32'd1207);
    #12;
    check("R6 reset enables", clk_en, 64'h3);
    check("R6 reset rd_data", {32'h0, rd_data}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    do_write(3'd0, 32'hFFFF_FFFF, "R1 set all bank0");
    do_write(3'd1, 32'hFFFF_FFFF, "R2 R4 clear all bank0");
    do_read(3'd2, "R4 status pinned bits");
    do_write(3'd0, 32'h0000_00F0, "R1 set nibble");
    do_write(3'd0, 32'h0000_0000, "R1 zero set no effect");
    do_write(3'd1, 32'h0000_0000, "R2 zero clear no effect");
    do_write(3'd1, 32'h0000_0030, "R2 partial clear");
    do_write(3'd4, 32'h0000_0001, "R5 set peripheral 32");
    do_write(3'd4, 32'h8000_0000, "R5 set peripheral 63");
    do_read(3'd6, "R5 R3 status bank1");
    do_read(3'd2, "R3 status bank0");
    do_write(3'd5, 32'hFFFF_FFFF, "R5 clear bank1 only");
    do_write(3'd2, 32'hFFFF_FFFF, "R8 write to status");
    do_write(3'd3, 32'hFFFF_FFFF, "R8 write to reserved");
    do_write(3'd7, 32'h0000_0000, "R8 write to reserved bank1");
    do_read(3'd3, "R8 read reserved");
    do_read(3'd0, "R8 read set word");
    do_read(3'd5, "R8 read clear word bank1");

    // R7: write data present but strobe low
    @(negedge clk);
    addr = 3'd0; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R7 no strobe no change", clk_en, model);

    // R3: rd_data holds while rd_en low
    do_read(3'd2, "R3 status before hold");
    do_write(3'd0, 32'h0F0F_0000, "R1 set after read");
    addr = 3'd6;
    @(negedge clk);
    check("R3 rd_data held", {32'h0, rd_data}, {32'h0, 32'h0000_00C3});

    for (int i = 0; i < 400; i++) begin
      logic [2:0]  a = 3'($urandom);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 2) == 0) do_read(a, "R3 R8 random read");
      else                           do_write(a, d, "R1 R2 R5 random write");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule